// File: doc/BRIEF.md
# Locking Packet Timestamp Capture

This block stores a snapshot of the free-running system time when a pre-decoded packet event strobe arrives, and keeps it in a 64-bit holding register with a valid flag. A packet parser upstream supplies the strobe. With the strobe it gives the protocol version, whether the frame was carried at layer 2 or over UDP, the message type, the UDP destination port and the Ethertype. The block does no parsing of its own. One instance serves the transmit path and another serves the receive path. The parameter `RX_FILTER` decides whether the receive-side event filter is built in.

The holding register is single-entry and locks on capture. Once a timestamp is held, later events are dropped. Software reads the held value as a low word and a high word. The read strobe that marks the high-word access clears the valid flag and re-arms the capture. If that read is missed, all further timestamping stops until it happens.

On the receive side, a two-bit mode field chooses what is stamped. One mode accepts version-1 events over UDP, and only of one configured message type. The other mode accepts every version-2 event. In that mode, layer-2 frames are accepted only when a separate Ethertype filter allows them.

Top module: `ts_capture`

## Requirements
- R1: After reset, ts_valid is 0 and ts_hi/ts_lo are both 0.
- R2: An accepted event strobe while ts_valid is 0 loads sys_time as sampled at that clock edge, with the upper 32 bits on ts_hi and the lower 32 bits on ts_lo. ts_valid is 1 from the following cycle.
- R3: While ts_valid is 1, further accepted events leave ts_hi/ts_lo unchanged and ts_valid stays 1 until rd_hi.
- R4: A cycle with rd_hi high and ts_valid 1 clears ts_valid. The next accepted event is then captured again.
- R5: With cfg_enable 0 no event is captured, and ts_valid stays 0.
- R6: Receive mode cfg_mode=2'b01 (version-1 over UDP) accepts only events that meet all of the following: evt_ver2=0, evt_layer2=0, evt_udp_port equal to cfg_udp_port, and evt_msg equal to cfg_msg.
- R7: Receive mode cfg_mode=2'b10 (all version-2) accepts UDP events with evt_ver2=1 and a matching port, whatever evt_msg holds. It rejects version-1 events.
- R8: In mode 2'b10, a layer-2 event (evt_layer2=1, evt_ver2=1) is accepted only when cfg_l2_en and cfg_l2_stamp are both 1 and evt_ethertype equals 16'h88F7.
- R9: Receive modes 2'b00 and 2'b11 accept no event.
- R10: An instance built with RX_FILTER=0 (transmit) captures every strobe while enabled, whatever the type inputs hold.
- R11: If rd_hi and an event coincide while ts_valid is 1, ts_valid clears, the event is dropped, and the held value is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time | input | 64 | Current system time |
| evt_strobe | input | 1 | Pre-decoded event strobe, one cycle |
| evt_ver2 | input | 1 | 1 = version-2 message, 0 = version-1 |
| evt_layer2 | input | 1 | 1 = layer-2 frame, 0 = carried over UDP |
| evt_msg | input | 8 | Message type code |
| evt_udp_port | input | 16 | UDP destination port |
| evt_ethertype | input | 16 | Frame Ethertype |
| cfg_enable | input | 1 | Capture enable |
| cfg_mode | input | 2 | Receive type: 01 version-1 UDP, 10 all version-2 |
| cfg_msg | input | 8 | Version-1 message type to stamp |
| cfg_udp_port | input | 16 | Event UDP port to match |
| cfg_l2_en | input | 1 | Ethertype filter entry enable |
| cfg_l2_stamp | input | 1 | Ethertype filter entry timestamp flag |
| rd_hi | input | 1 | High-word read strobe; releases the lock |
| ts_lo | output | 32 | Held timestamp, low word |
| ts_hi | output | 32 | Held timestamp, high word |
| ts_valid | output | 1 | A timestamp is held |

## Verification
The hardest case to reach is a read that lands on the same edge as a new event while the register is locked. Here the release and the dropped capture compete. The bench first locks the register, then raises rd_hi and the strobe together with a fresh sys_time value. It then checks that the flag clears and the old value survives. The filter cases come from a table: each row frees the lock, sets the configuration, fires one event with its own time value, and checks both the receive and the transmit instance.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
  typedef enum logic [1:0] {
    RXM_NONE  = 2'b00,
    RXM_V1L4  = 2'b01,
    RXM_V2ALL = 2'b10,
    RXM_RSVD  = 2'b11
  } rx_mode_e;

  localparam logic [15:0] L2_EVENT_ETYPE = 16'h88F7;

  // Receive-side acceptance rule for one event.
  function automatic logic rx_accept(
    input logic [1:0]  mode,
    input logic        ver2,
    input logic        layer2,
    input logic [7:0]  msg,
    input logic [15:0] port,
    input logic [15:0] etype,
    input logic [7:0]  want_msg,
    input logic [15:0] want_port,
    input logic        l2_en,
    input logic        l2_stamp
  );
    logic port_ok, l2_ok;
    port_ok = (port == want_port);
    l2_ok   = l2_en && l2_stamp && (etype == L2_EVENT_ETYPE);
    unique case (rx_mode_e'(mode))
      RXM_V1L4:  rx_accept = !ver2 && !layer2 && port_ok && (msg == want_msg);
      RXM_V2ALL: rx_accept = ver2 && (layer2 ? l2_ok : port_ok);
      default:   rx_accept = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/ts_evt_filter.sv
module ts_evt_filter
  import ts_cap_pkg::*;
#(
  parameter bit RX_FILTER = 1'b1,
  parameter int MSG_W     = 8,
  parameter int PORT_W    = 16
) (
  input  logic              strobe,
  input  logic              enable,
  input  logic              ver2,
  input  logic              layer2,
  input  logic [MSG_W-1:0]  msg,
  input  logic [PORT_W-1:0] port,
  input  logic [15:0]       etype,
  input  logic [1:0]        mode,
  input  logic [MSG_W-1:0]  want_msg,
  input  logic [PORT_W-1:0] want_port,
  input  logic              l2_en,
  input  logic              l2_stamp,
  output logic              accept
);
  logic type_ok;

  generate
    if (RX_FILTER) begin : g_rx
      always_comb type_ok = rx_accept(mode, ver2, layer2, 8'(msg), 16'(port), etype,
                                      8'(want_msg), 16'(want_port), l2_en, l2_stamp);
    end else begin : g_tx
      assign type_ok = 1'b1;
    end
  endgenerate

  assign accept = strobe && enable && type_ok;
endmodule

// File: rtl/ts_hold_reg.sv
module ts_hold_reg #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] now,
  input  logic            accept,
  input  logic            release_lock,
  output logic            cap_fire,
  output logic [TS_W-1:0] held,
  output logic            valid
);
  assign cap_fire = accept && !valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held  <= '0;
      valid <= 1'b0;
    end else begin
      if (release_lock) valid <= 1'b0;
      if (cap_fire) begin
        held  <= now;
        valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ts_capture.sv
module ts_capture #(
  parameter bit RX_FILTER = 1'b1,
  parameter int TS_W      = 64,
  parameter int MSG_W     = 8,
  parameter int PORT_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TS_W-1:0]     sys_time,
  input  logic                evt_strobe,
  input  logic                evt_ver2,
  input  logic                evt_layer2,
  input  logic [MSG_W-1:0]    evt_msg,
  input  logic [PORT_W-1:0]   evt_udp_port,
  input  logic [15:0]         evt_ethertype,
  input  logic                cfg_enable,
  input  logic [1:0]          cfg_mode,
  input  logic [MSG_W-1:0]    cfg_msg,
  input  logic [PORT_W-1:0]   cfg_udp_port,
  input  logic                cfg_l2_en,
  input  logic                cfg_l2_stamp,
  input  logic                rd_hi,
  output logic [TS_W/2-1:0]   ts_lo,
  output logic [TS_W/2-1:0]   ts_hi,
  output logic                ts_valid
);
  localparam int HALF = TS_W / 2;

  logic            evt_accept;
  logic            cap_fire;
  logic [TS_W-1:0] held;

  ts_evt_filter #(.RX_FILTER(RX_FILTER), .MSG_W(MSG_W), .PORT_W(PORT_W)) u_filt (
    .strobe(evt_strobe), .enable(cfg_enable), .ver2(evt_ver2), .layer2(evt_layer2),
    .msg(evt_msg), .port(evt_udp_port), .etype(evt_ethertype), .mode(cfg_mode),
    .want_msg(cfg_msg), .want_port(cfg_udp_port), .l2_en(cfg_l2_en),
    .l2_stamp(cfg_l2_stamp), .accept(evt_accept)
  );

  ts_hold_reg #(.TS_W(TS_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .now(sys_time), .accept(evt_accept),
    .release_lock(rd_hi), .cap_fire(cap_fire), .held(held), .valid(ts_valid)
  );

  assign ts_lo = held[HALF-1:0];
  assign ts_hi = held[TS_W-1:HALF];
endmodule

// File: rtl/ts_capture_chk.sv
module ts_capture_chk #(
  parameter int TS_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic [TS_W-1:0] sys_time,
  input logic            cfg_enable,
  input logic            rd_hi,
  input logic            cap_fire,
  input logic            evt_accept,
  input logic [TS_W/2-1:0] ts_lo,
  input logic [TS_W/2-1:0] ts_hi,
  input logic            ts_valid
);
  // R2
  a_r2_capture_time: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> ts_valid && ({ts_hi, ts_lo} == $past(sys_time)));
  // R3
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ts_valid |=> $stable({ts_hi, ts_lo}));
  a_r3_lock_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ts_valid && !rd_hi |=> ts_valid);
  // R4 and R11
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    ts_valid && rd_hi |=> !ts_valid);
  // R5
  a_r5_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable && !ts_valid |=> !ts_valid);
  a_r5_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> !evt_accept);
endmodule

bind ts_capture ts_capture_chk #(.TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_time(sys_time), .cfg_enable(cfg_enable),
  .rd_hi(rd_hi), .cap_fire(cap_fire), .evt_accept(evt_accept),
  .ts_lo(ts_lo), .ts_hi(ts_hi), .ts_valid(ts_valid)
);

// File: tb/ts_capture_bench.sv
module ts_capture_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [63:0] sys_time;
  logic        evt_strobe, evt_ver2, evt_layer2;
  logic [7:0]  evt_msg;
  logic [15:0] evt_udp_port, evt_ethertype;
  logic        cfg_enable;
  logic [1:0]  cfg_mode;
  logic [7:0]  cfg_msg;
  logic [15:0] cfg_udp_port;
  logic        cfg_l2_en, cfg_l2_stamp, rd_hi;
  logic [31:0] ts_lo, ts_hi, tx_lo, tx_hi;
  logic        ts_valid, tx_valid;

  ts_capture u_ts_capture (
    .clk, .rst_n, .sys_time, .evt_strobe, .evt_ver2, .evt_layer2, .evt_msg,
    .evt_udp_port, .evt_ethertype, .cfg_enable, .cfg_mode, .cfg_msg, .cfg_udp_port,
    .cfg_l2_en, .cfg_l2_stamp, .rd_hi, .ts_lo, .ts_hi, .ts_valid);

  ts_capture #(.RX_FILTER(1'b0)) u_ts_capture_tx (
    .clk, .rst_n, .sys_time, .evt_strobe, .evt_ver2, .evt_layer2, .evt_msg,
    .evt_udp_port, .evt_ethertype, .cfg_enable, .cfg_mode, .cfg_msg, .cfg_udp_port,
    .cfg_l2_en, .cfg_l2_stamp, .rd_hi, .ts_lo(tx_lo), .ts_hi(tx_hi), .ts_valid(tx_valid));

  int n_cmp = 0, n_bad = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  mode;
    logic        en;
    logic        ver2;
    logic        l2;
    logic [7:0]  msg;
    logic [15:0] port;
    logic [15:0] etype;
    logic        l2en;
    logic        l2st;
    logic        rx_exp;
  } vec_t;

  // cfg_msg = 8'h01, cfg_udp_port = 16'd319 throughout
  localparam vec_t VECS [12] = '{
    '{2'b01, 1'b1, 1'b0, 1'b0, 8'h01, 16'd319, 16'h0800, 1'b0, 1'b0, 1'b1}, // R6 match
    '{2'b01, 1'b1, 1'b0, 1'b0, 8'h00, 16'd319, 16'h0800, 1'b0, 1'b0, 1'b0}, // R6 wrong msg
    '{2'b01, 1'b1, 1'b0, 1'b0, 8'h01, 16'd320, 16'h0800, 1'b0, 1'b0, 1'b0}, // R6 wrong port
    '{2'b01, 1'b1, 1'b1, 1'b0, 8'h01, 16'd319, 16'h0800, 1'b0, 1'b0, 1'b0}, // R6 v2 rejected
    '{2'b10, 1'b1, 1'b1, 1'b0, 8'h0B, 16'd319, 16'h0800, 1'b0, 1'b0, 1'b1}, // R7 any msg
    '{2'b10, 1'b1, 1'b0, 1'b0, 8'h01, 16'd319, 16'h0800, 1'b0, 1'b0, 1'b0}, // R7 v1 rejected
    '{2'b10, 1'b1, 1'b1, 1'b1, 8'h00, 16'd0,   16'h88F7, 1'b1, 1'b1, 1'b1}, // R8 l2 ok
    '{2'b10, 1'b1, 1'b1, 1'b1, 8'h00, 16'd0,   16'h88F7, 1'b1, 1'b0, 1'b0}, // R8 no stamp flag
    '{2'b10, 1'b1, 1'b1, 1'b1, 8'h00, 16'd0,   16'h88F8, 1'b1, 1'b1, 1'b0}, // R8 wrong etype
    '{2'b00, 1'b1, 1'b1, 1'b0, 8'h01, 16'd319, 16'h0800, 1'b1, 1'b1, 1'b0}, // R9 mode 00
    '{2'b11, 1'b1, 1'b0, 1'b0, 8'h01, 16'd319, 16'h0800, 1'b1, 1'b1, 1'b0}, // R9 mode 11
    '{2'b01, 1'b0, 1'b0, 1'b0, 8'h01, 16'd319, 16'h0800, 1'b0, 1'b0, 1'b0}  // R5 disabled
  };

  task automatic release_lock();
    @(negedge clk) rd_hi = 1'b1;
    @(negedge clk) rd_hi = 1'b0;
  endtask

  task automatic fire(logic [63:0] t);
    @(negedge clk);
    sys_time = t;
    evt_strobe = 1'b1;
    @(negedge clk);
    evt_strobe = 1'b0;
    sys_time = ~t;
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sys_time = '0; evt_strobe = 1'b0; evt_ver2 = 1'b0; evt_layer2 = 1'b0;
    evt_msg = '0; evt_udp_port = '0; evt_ethertype = '0; cfg_enable = 1'b0;
    cfg_mode = 2'b00; cfg_msg = 8'h01; cfg_udp_port = 16'd319;
    cfg_l2_en = 1'b0; cfg_l2_stamp = 1'b0; rd_hi = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", {63'd0, ts_valid}, 64'd0);
    check("R1 value", {ts_hi, ts_lo}, 64'd0);
    rst_n = 1'b1;

    foreach (VECS[i]) begin
      logic [63:0] t;
      t = 64'hA5A5_0000_0000_1000 + 64'(i) * 64'h0001_0003_0000_0007;
      release_lock();
      cfg_mode = VECS[i].mode; cfg_enable = VECS[i].en; evt_ver2 = VECS[i].ver2;
      evt_layer2 = VECS[i].l2; evt_msg = VECS[i].msg; evt_udp_port = VECS[i].port;
      evt_ethertype = VECS[i].etype; cfg_l2_en = VECS[i].l2en; cfg_l2_stamp = VECS[i].l2st;
      fire(t);
      check($sformatf("R6-R9/R5 row %0d rx valid", i), {63'd0, ts_valid}, {63'd0, VECS[i].rx_exp});
      if (VECS[i].rx_exp) check($sformatf("R2 row %0d rx time", i), {ts_hi, ts_lo}, t);
      // R10 transmit instance ignores type inputs
      check($sformatf("R10 row %0d tx valid", i), {63'd0, tx_valid}, {63'd0, VECS[i].en});
      if (VECS[i].en) check($sformatf("R10 row %0d tx time", i), {tx_hi, tx_lo}, t);
    end

    // R3 lock holds value against a second event
    release_lock();
    cfg_enable = 1'b1; cfg_mode = 2'b01; evt_ver2 = 1'b0; evt_layer2 = 1'b0;
    evt_msg = 8'h01; evt_udp_port = 16'd319;
    fire(64'h1111_2222_3333_4444);
    fire(64'h5555_6666_7777_8888);
    check("R3 held value", {ts_hi, ts_lo}, 64'h1111_2222_3333_4444);
    check("R3 still valid", {63'd0, ts_valid}, 64'd1);

    // R11 read and event on the same edge while locked
    @(negedge clk);
    sys_time = 64'h9999_AAAA_BBBB_CCCC; evt_strobe = 1'b1; rd_hi = 1'b1;
    @(negedge clk);
    evt_strobe = 1'b0; rd_hi = 1'b0;
    check("R11 valid cleared", {63'd0, ts_valid}, 64'd0);
    check("R11 value kept", {ts_hi, ts_lo}, 64'h1111_2222_3333_4444);

    // R4 re-arm after release
    fire(64'h0123_4567_89AB_CDEF);
    check("R4 rearmed valid", {63'd0, ts_valid}, 64'd1);
    check("R4 rearmed value", {ts_hi, ts_lo}, 64'h0123_4567_89AB_CDEF);
    release_lock();
    check("R4 released", {63'd0, ts_valid}, 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule